// File: doc/BRIEF.md
# Vectored Interrupt Event Controller

This block is the interrupt front end of a small 4-bit microcontroller core. Five single-cycle hardware event pulses are caught in an 8-bit event-flag register: divider 0 overflow, timer 0 underflow, port change, divider 1 overflow and timer 1 underflow. Each flag is qualified by its bit in an 8-bit enable register and by a global enable. When at least one qualified flag is pending, the block raises a request. With it, the block gives a fixed program address for the handler and a one-hot mark of the winning flag.

The core reaches the block only through command strobes. These are: acknowledge, global enable, global disable, a write of the enable register with an immediate value, and a flag clear with an immediate mask. Accepting an interrupt clears only the serviced flag and drops the global enable, so no further interrupt is taken until software turns it back on. While the core sits in hold mode, a pending request also drives a wake output.

Top module: `irq_evt_ctrl`

## Requirements
- R1: A pulse on a source input sets its flag in `evt_flags_o` one clock edge later. The bit positions are: divider 0 on bit 0, timer 0 on bit 1, port change on bit 2, divider 1 on bit 4 and timer 1 on bit 7. Bits 3, 5 and 6 always read 0.
- R2: While `irq_o` is 1, `vec_o` is 4*(winning bit+1). That gives 0x004, 0x008, 0x00C, 0x014 or 0x020. While `irq_o` is 0, `vec_o` is 0.
- R3: A clear strobe clears every flag whose bit is 1 in the clear mask and leaves the other flags as they are. An event that arrives in the same cycle as a clear of its own flag (by mask or by acknowledge) wins, and the flag stays 1.
- R4: `irq_o` is 1 exactly when some flag and its enable bit are both 1 and the global enable is on. It is combinational from the registered state.
- R5: A write strobe loads the whole enable register from `ien_data_i` and turns the global enable on.
- R6: An acknowledge taken while `irq_o` is 1 clears only the winning flag. An acknowledge while `irq_o` is 0 changes nothing.
- R7: When several qualified flags are pending, the lowest-numbered bit wins. `win_o` is the one-hot mark of that bit, and `win_o` is 0 when there is no request.
- R8: An accepted acknowledge turns the global enable off. An enable strobe or a write strobe turns it back on, and a disable strobe turns it off. In one cycle, an accepted acknowledge or a disable strobe overrides an enable or write strobe.
- R9: `wake_o` equals `hold_i` AND `irq_o`.
- R10: After reset, the flags and enable register are 0, the global enable is off, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_div0_i | input | 1 | Divider 0 overflow pulse |
| evt_tmr0_i | input | 1 | Timer 0 underflow pulse |
| evt_port_i | input | 1 | Port change pulse |
| evt_div1_i | input | 1 | Divider 1 overflow pulse |
| evt_tmr1_i | input | 1 | Timer 1 underflow pulse |
| gie_en_i | input | 1 | Global enable strobe |
| gie_dis_i | input | 1 | Global disable strobe |
| ien_wr_i | input | 1 | Enable register write strobe |
| ien_data_i | input | 8 | Enable register immediate value |
| flag_clr_i | input | 1 | Flag clear strobe |
| flag_clr_mask_i | input | 8 | Flag clear immediate mask |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| hold_i | input | 1 | Core is in hold mode |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 12 | Handler address of the winner |
| win_o | output | 8 | One-hot winning flag |
| wake_o | output | 1 | Wake request in hold mode |
| evt_flags_o | output | 8 | Event-flag register |

## Verification
Every strobe and event pulse acts on the next rising edge. Flag and enable changes therefore appear on `evt_flags_o` one edge later. `irq_o`, `vec_o` and `win_o` follow that same edge with no extra register, and `wake_o` follows `hold_i` with no clock at all. The bench drives each stimulus just after a rising edge. It samples one time unit after the next rising edge, or, for `hold_i`, one time unit after changing it. Each check therefore falls in the cycle where the result is first due.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int FLAG_W   = 8;
  localparam int VEC_W    = 12;
  localparam int VEC_STEP = 4;
  localparam int IDX_W    = $clog2(FLAG_W);

  localparam int BIT_DIV0 = 0;
  localparam int BIT_TMR0 = 1;
  localparam int BIT_PORT = 2;
  localparam int BIT_DIV1 = 4;
  localparam int BIT_TMR1 = 7;

  localparam logic [FLAG_W-1:0] USED_MASK =
    FLAG_W'((1 << BIT_DIV0) | (1 << BIT_TMR0) | (1 << BIT_PORT) |
            (1 << BIT_DIV1) | (1 << BIT_TMR1));
endpackage

// File: rtl/irq_evt_flags.sv
module irq_evt_flags #(
  parameter int                FLAG_W    = 8,
  parameter logic [FLAG_W-1:0] USED_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic [FLAG_W-1:0] flags_q;

  // set dominates clear so a coincident event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= ((flags_q & ~clr_i) | set_i) & USED_MASK;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_evt_prio.sv
module irq_evt_prio #(
  parameter int FLAG_W   = 8,
  parameter int VEC_W    = 12,
  parameter int VEC_STEP = 4,
  localparam int IDX_W   = $clog2(FLAG_W)
) (
  input  logic [FLAG_W-1:0] pend_i,
  output logic              any_o,
  output logic [FLAG_W-1:0] win_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [IDX_W-1:0] idx;

  // scan high to low so the lowest pending bit is kept last
  always_comb begin
    win_o = '0;
    idx   = '0;
    for (int i = FLAG_W - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        win_o    = '0;
        win_o[i] = 1'b1;
        idx      = i[IDX_W-1:0];
      end
    end
  end

  assign any_o = |pend_i;
  assign vec_o = any_o ? VEC_W'((32'(idx) + 1) * VEC_STEP) : '0;
endmodule

// File: rtl/irq_evt_gate.sv
module irq_evt_gate #(
  parameter int FLAG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              en_i,
  input  logic              dis_i,
  input  logic              wr_i,
  input  logic [FLAG_W-1:0] wr_data_i,
  output logic [FLAG_W-1:0] ien_o,
  output logic              gie_o
);
  logic [FLAG_W-1:0] ien_q;
  logic              gie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ien_q <= '0;
    else if (wr_i) ien_q <= wr_data_i;
  end

  // blocking events override re-arming in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gie_q <= 1'b0;
    else if (accept_i)      gie_q <= 1'b0;
    else if (dis_i)         gie_q <= 1'b0;
    else if (en_i || wr_i)  gie_q <= 1'b1;
  end

  assign ien_o = ien_q;
  assign gie_o = gie_q;
endmodule

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
  import irq_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_div0_i,
  input  logic              evt_tmr0_i,
  input  logic              evt_port_i,
  input  logic              evt_div1_i,
  input  logic              evt_tmr1_i,
  input  logic              gie_en_i,
  input  logic              gie_dis_i,
  input  logic              ien_wr_i,
  input  logic [FLAG_W-1:0] ien_data_i,
  input  logic              flag_clr_i,
  input  logic [FLAG_W-1:0] flag_clr_mask_i,
  input  logic              ack_i,
  input  logic              hold_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [FLAG_W-1:0] win_o,
  output logic              wake_o,
  output logic [FLAG_W-1:0] evt_flags_o
);
  logic [FLAG_W-1:0] set_vec, clr_vec, flags, ien, pend;
  logic              gie_q, accept, any;

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_DIV0] = evt_div0_i;
    set_vec[BIT_TMR0] = evt_tmr0_i;
    set_vec[BIT_PORT] = evt_port_i;
    set_vec[BIT_DIV1] = evt_div1_i;
    set_vec[BIT_TMR1] = evt_tmr1_i;
  end

  assign accept  = ack_i & irq_o;
  assign clr_vec = (flag_clr_i ? flag_clr_mask_i : '0) | (accept ? win_o : '0);

  irq_evt_flags #(.FLAG_W(FLAG_W), .USED_MASK(USED_MASK)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flags)
  );

  irq_evt_gate #(.FLAG_W(FLAG_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .en_i      (gie_en_i),
    .dis_i     (gie_dis_i),
    .wr_i      (ien_wr_i),
    .wr_data_i (ien_data_i),
    .ien_o     (ien),
    .gie_o     (gie_q)
  );

  assign pend = gie_q ? (flags & ien & USED_MASK) : '0;

  irq_evt_prio #(.FLAG_W(FLAG_W), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u_prio (
    .pend_i (pend),
    .any_o  (any),
    .win_o  (win_o),
    .vec_o  (vec_o)
  );

  assign irq_o       = any;
  assign wake_o      = hold_i & irq_o;
  assign evt_flags_o = flags;
endmodule

// File: rtl/irq_evt_ctrl_chk.sv
module irq_evt_ctrl_chk
  import irq_evt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gie_q,
  input logic [FLAG_W-1:0] ien,
  input logic              ack_i,
  input logic              hold_i,
  input logic              flag_clr_i,
  input logic [FLAG_W-1:0] flag_clr_mask_i,
  input logic              irq_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic [FLAG_W-1:0] win_o,
  input logic              wake_o,
  input logic [FLAG_W-1:0] evt_flags_o
);
  a_r1_unused_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_flags_o & ~USED_MASK) == '0);

  a_r2_vec_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[1:0] == 2'b00 && vec_o != '0));

  a_r4_req_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (gie_q && (evt_flags_o & ien) != '0));

  a_r6_others_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !flag_clr_i) |=>
      ((evt_flags_o & $past(evt_flags_o & ~win_o)) == $past(evt_flags_o & ~win_o)));

  a_r7_win_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_o) && (irq_o == (win_o != '0)));

  a_r7_win_in_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_o & ~evt_flags_o) == '0);

  a_r8_ack_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> !irq_o);

  a_r9_wake_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (hold_i && irq_o));

  a_r9_wake_on_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && irq_o) |-> wake_o);

  logic unused_mask;
  assign unused_mask = ^flag_clr_mask_i;
endmodule

bind irq_evt_ctrl irq_evt_ctrl_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .gie_q           (gie_q),
  .ien             (ien),
  .ack_i           (ack_i),
  .hold_i          (hold_i),
  .flag_clr_i      (flag_clr_i),
  .flag_clr_mask_i (flag_clr_mask_i),
  .irq_o           (irq_o),
  .vec_o           (vec_o),
  .win_o           (win_o),
  .wake_o          (wake_o),
  .evt_flags_o     (evt_flags_o)
);

// File: tb/irq_evt_ctrl_bench.sv
module irq_evt_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       evt_div0_i, evt_tmr0_i, evt_port_i, evt_div1_i, evt_tmr1_i;
  logic       gie_en_i, gie_dis_i, ien_wr_i, flag_clr_i, ack_i, hold_i;
  logic [7:0] ien_data_i, flag_clr_mask_i;
  logic       irq_o, wake_o;
  logic [11:0] vec_o;
  logic [7:0] win_o, evt_flags_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  irq_evt_ctrl u_irq_evt_ctrl (
    .clk_i, .rst_ni, .evt_div0_i, .evt_tmr0_i, .evt_port_i, .evt_div1_i,
    .evt_tmr1_i, .gie_en_i, .gie_dis_i, .ien_wr_i, .ien_data_i, .flag_clr_i,
    .flag_clr_mask_i, .ack_i, .hold_i, .irq_o, .vec_o, .win_o, .wake_o,
    .evt_flags_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    {evt_div0_i, evt_tmr0_i, evt_port_i, evt_div1_i, evt_tmr1_i} = '0;
    {gie_en_i, gie_dis_i, ien_wr_i, flag_clr_i, ack_i} = '0;
    ien_data_i = '0;
    flag_clr_mask_i = '0;
  endtask

  // apply strobes set by caller on the next edge, then sample
  task automatic tick();
    @(posedge clk_i);
    #1;
    idle();
  endtask

  task automatic clear_all();
    flag_clr_i = 1; flag_clr_mask_i = 8'hFF; tick();
  endtask

  task automatic t_reset();
    chk("R10", "flags", evt_flags_o, 0);
    chk("R10", "irq", irq_o, 0);
    chk("R10", "vec", vec_o, 0);
    chk("R10", "win", win_o, 0);
    chk("R10", "wake", wake_o, 0);
  endtask

  task automatic t_map();
    evt_div0_i = 1; tick(); chk("R1", "div0 bit0", evt_flags_o, 8'h01);
    evt_tmr0_i = 1; tick(); chk("R1", "tmr0 bit1", evt_flags_o, 8'h03);
    evt_port_i = 1; tick(); chk("R1", "port bit2", evt_flags_o, 8'h07);
    evt_div1_i = 1; tick(); chk("R1", "div1 bit4", evt_flags_o, 8'h17);
    evt_tmr1_i = 1; tick(); chk("R1", "tmr1 bit7", evt_flags_o, 8'h97);
    chk("R4", "no irq without enable", irq_o, 0);
    flag_clr_i = 1; flag_clr_mask_i = 8'h12; tick();
    chk("R3", "masked clear", evt_flags_o, 8'h85);
    clear_all();
    chk("R3", "clear all", evt_flags_o, 0);
  endtask

  task automatic t_gate();
    evt_div0_i = 1; tick();
    chk("R4", "flag only, no irq", irq_o, 0);
    ien_wr_i = 1; ien_data_i = 8'h01; tick();
    chk("R5", "write arms irq", irq_o, 1);
    chk("R2", "vec bit0", vec_o, 12'h004);
    chk("R7", "win bit0", win_o, 8'h01);
    gie_dis_i = 1; tick();
    chk("R8", "disable", irq_o, 0);
    chk("R2", "vec zero idle", vec_o, 0);
    gie_en_i = 1; tick();
    chk("R8", "enable", irq_o, 1);
    ien_wr_i = 1; ien_data_i = 8'h02; tick();
    chk("R5", "enable bit0 cleared", irq_o, 0);
    clear_all();
  endtask

  task automatic t_prio();
    ien_wr_i = 1; ien_data_i = 8'hFF; tick();
    evt_port_i = 1; evt_div1_i = 1; evt_tmr1_i = 1; tick();
    chk("R7", "lowest wins port", win_o, 8'h04);
    chk("R2", "vec bit2", vec_o, 12'h00C);
    ack_i = 1; tick();
    chk("R6", "ack clears only bit2", evt_flags_o, 8'h90);
    chk("R8", "ack blocks", irq_o, 0);
    gie_en_i = 1; tick();
    chk("R7", "next winner div1", win_o, 8'h10);
    chk("R2", "vec bit4", vec_o, 12'h014);
    ack_i = 1; tick();
    chk("R6", "ack clears bit4", evt_flags_o, 8'h80);
    gie_en_i = 1; tick();
    chk("R2", "vec bit7", vec_o, 12'h020);
    chk("R7", "win bit7", win_o, 8'h80);
    ack_i = 1; tick();
    chk("R6", "ack clears bit7", evt_flags_o, 0);
  endtask

  task automatic t_ack_ignored();
    gie_dis_i = 1; tick();
    evt_div0_i = 1; tick();
    ack_i = 1; tick();
    chk("R6", "ack without irq ignored", evt_flags_o, 8'h01);
    gie_en_i = 1; tick();
    chk("R6", "irq still available", irq_o, 1);
    clear_all();
  endtask

  task automatic t_clr_race();
    evt_tmr0_i = 1; tick();
    flag_clr_i = 1; flag_clr_mask_i = 8'h02; evt_tmr0_i = 1; tick();
    chk("R3", "event beats clear", evt_flags_o, 8'h02);
    flag_clr_i = 1; flag_clr_mask_i = 8'h01; tick();
    chk("R3", "other bit untouched", evt_flags_o, 8'h02);
    ack_i = 1; evt_tmr0_i = 1; tick();
    chk("R3", "event beats ack clear", evt_flags_o, 8'h02);
    chk("R8", "ack still blocks", irq_o, 0);
    clear_all();
  endtask

  task automatic t_wake();
    gie_en_i = 1; evt_div1_i = 1; tick();
    chk("R9", "no hold no wake", wake_o, 0);
    hold_i = 1; #1;
    chk("R9", "wake in hold", wake_o, 1);
    gie_dis_i = 1; tick();
    chk("R9", "no wake when blocked", wake_o, 0);
    hold_i = 0;
    clear_all();
  endtask

  task automatic t_cmd_order();
    evt_tmr0_i = 1; gie_en_i = 1; tick();
    chk("R4", "armed", irq_o, 1);
    ack_i = 1; gie_en_i = 1; tick();
    chk("R8", "ack overrides enable", irq_o, 0);
    evt_tmr0_i = 1; gie_en_i = 1; gie_dis_i = 1; tick();
    chk("R8", "disable overrides enable", irq_o, 0);
    ien_wr_i = 1; ien_data_i = 8'hFF; gie_dis_i = 1; tick();
    chk("R8", "disable overrides write", irq_o, 0);
    gie_en_i = 1; tick();
    chk("R8", "re-armed", irq_o, 1);
    clear_all();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    hold_i = 0;
    #(CLK_PERIOD * 3 + 2);
    t_reset();
    rst_ni = 1;
    tick();
    t_map();
    t_gate();
    t_prio();
    t_ack_ignored();
    t_clr_race();
    t_wake();
    t_cmd_order();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule